// File: doc/BRIEF.md
# Serial Audio Frame Deserializer

This block is the receiving end of a framed serial audio link. It runs on the falling edge of the link's bit clock and samples a frame marker line and a serial data line. A low-to-high change of the marker starts a frame. Each frame begins with a 16-bit tag slot, followed by a run of fixed-width data slots that arrive most significant bit first.

The first tag bit says whether the whole frame carries anything. The tag bits after it mark each data slot as occupied or empty. The block presents an occupied slot as a parallel word together with its slot number and a one-cycle strobe. It drops empty slots, and it drops every slot of a frame whose frame-valid bit is clear. The marker for the next frame is expected exactly as the last bit of the final slot is being sampled. A marker edge at any other time restarts the frame counters and pulses an error flag.

The slot width, slot count and tag width are parameters. The defaults give 12 slots of 20 bits and a 256-bit frame.

Top module: `audio_link_rx`

## Requirements
- R1: The sync and data inputs are sampled on falling edges of `bitClk`. A frame starts at the first falling edge where sync is sampled high after it was sampled low, and the first frame bit is sampled on the next falling edge. Sync held high does not restart the frame.
- R2: The first 16 frame bits form the tag slot. Its first bit is the frame-valid flag, and the bit received k positions later is the tag of data slot k (k = 1..SLOT_COUNT). Later tag bits are ignored.
- R3: Each data slot is SLOT_WIDTH bits, received MSB first. The presented `slotData` has its MSB equal to the first bit received in that slot.
- R4: A slot whose tag is 1 in a frame whose frame-valid flag is 1 is presented. `slotValid` is high for exactly one cycle, with `slotNum` equal to the slot number (1..SLOT_COUNT). All three outputs are registered on the falling edge that samples the slot's last bit.
- R5: A slot whose tag is 0 is discarded: `slotValid` stays low when that slot completes.
- R6: A frame whose frame-valid flag is 0 produces no `slotValid` pulse.
- R7: A sync rising edge detected on the falling edge that samples the last bit of the final slot is aligned. That bit still completes the final slot, and `frameErr` stays low.
- R8: A sync rising edge detected anywhere else within a frame restarts the frame counters. It also pulses `frameErr` for one cycle on that edge and discards the partly received slot.
- R9: After the final slot, if no sync edge arrives the receiver idles and presents nothing. The next sync rising edge then starts a frame and pulses `frameErr`. The first frame start after reset does not raise `frameErr`.
- R10: While `rstN` is low, `slotValid` and `frameErr` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bitClk | input | 1 | Link bit clock; all state changes on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Frame marker line |
| serData | input | 1 | Serial data line, MSB first |
| slotData | output | SLOT_WIDTH | Word of the most recently presented slot |
| slotNum | output | $clog2(SLOT_COUNT+1) | Number of the presented slot, 1..SLOT_COUNT |
| slotValid | output | 1 | One-cycle strobe qualifying `slotData` and `slotNum` |
| frameErr | output | 1 | One-cycle pulse on a misaligned or late frame start |

## Verification
The bench builds the receiver with four slots of eight bits, so each frame is 48 bit clocks. This lets a run cover many back-to-back frames, an early restart inside slot 2 and an idle gap before a late marker. Because the tag slot keeps its full 16 bits while only four tags are used, a table entry with ones in the ignored tag positions shows those bits have no effect. The tag patterns cover every slot set, every slot cleared with the frame flag set, and the frame flag cleared with all tags set.

// File: rtl/audio_link_rx_pkg.sv
`timescale 1ns/1ps
package audio_link_rx_pkg;

  // Per-bit commands from the frame sequencer to the slot datapath
  typedef struct packed {
    logic tagShift;   // capture this bit into the tag register
    logic slotShift;  // capture this bit into the slot shifter
    logic slotLast;   // this bit completes a slot that may be presented
  } rxStrobes_t;

endpackage

// File: rtl/rx_frame_ctrl.sv
`timescale 1ns/1ps
module rx_frame_ctrl
  import audio_link_rx_pkg::*;
#(
  parameter int TAG_WIDTH  = 16,
  parameter int SLOT_WIDTH = 20,
  parameter int SLOT_COUNT = 12,
  localparam int NUM_W = $clog2(SLOT_COUNT + 1),
  localparam int CNT_W = $clog2((TAG_WIDTH > SLOT_WIDTH) ? TAG_WIDTH : SLOT_WIDTH)
) (
  input  logic             bitClk,
  input  logic             rstN,
  input  logic             syncIn,
  output rxStrobes_t       strobes,
  output logic [NUM_W-1:0] slotIdx,
  output logic             frameErr
);

  localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(TAG_WIDTH - 1);
  localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(SLOT_WIDTH - 1);
  localparam logic [NUM_W-1:0] FINAL    = NUM_W'(SLOT_COUNT);

  logic             syncQ;
  logic             active;
  logic             seenStart;
  logic [CNT_W-1:0] bitInSlot;
  logic             startDet;
  logic             aligned;
  logic             inTag;

  always_comb begin
    startDet = syncIn && !syncQ;
    inTag    = (slotIdx == '0);
    aligned  = active && (slotIdx == FINAL) && (bitInSlot == SLOT_END);
    strobes.tagShift  = active && inTag && (int'(bitInSlot) <= SLOT_COUNT);
    strobes.slotShift = active && !inTag;
    strobes.slotLast  = active && !inTag && (bitInSlot == SLOT_END) &&
                        !(startDet && !aligned);
  end

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= 1'b1;
      active    <= 1'b0;
      seenStart <= 1'b0;
      bitInSlot <= '0;
      slotIdx   <= '0;
      frameErr  <= 1'b0;
    end else begin
      syncQ    <= syncIn;
      frameErr <= startDet && seenStart && !aligned;
      if (startDet) begin
        active    <= 1'b1;
        seenStart <= 1'b1;
        bitInSlot <= '0;
        slotIdx   <= '0;
      end else if (active) begin
        if (inTag && bitInSlot == TAG_END) begin
          slotIdx   <= NUM_W'(1);
          bitInSlot <= '0;
        end else if (!inTag && bitInSlot == SLOT_END) begin
          bitInSlot <= '0;
          if (slotIdx == FINAL) active <= 1'b0;
          else slotIdx <= slotIdx + NUM_W'(1);
        end else begin
          bitInSlot <= bitInSlot + CNT_W'(1);
        end
      end
    end
  end

  // R1
  start_restart_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    startDet |=> (active && slotIdx == '0 && bitInSlot == '0));

  // R7
  aligned_quiet_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    (startDet && aligned) |=> !frameErr);

  // R8
  err_restart_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    frameErr |-> (active && slotIdx == '0 && bitInSlot == '0));

  // R9
  idle_silent_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    !active |-> !(strobes.tagShift || strobes.slotShift || strobes.slotLast));

endmodule

// File: rtl/rx_slot_datapath.sv
`timescale 1ns/1ps
module rx_slot_datapath
  import audio_link_rx_pkg::*;
#(
  parameter int SLOT_WIDTH = 20,
  parameter int SLOT_COUNT = 12,
  localparam int NUM_W = $clog2(SLOT_COUNT + 1)
) (
  input  logic                  bitClk,
  input  logic                  rstN,
  input  logic                  serData,
  input  rxStrobes_t            strobes,
  input  logic [NUM_W-1:0]      slotIdx,
  output logic [SLOT_WIDTH-1:0] slotData,
  output logic [NUM_W-1:0]      slotNum,
  output logic                  slotValid
);

  // tagReg[SLOT_COUNT] is the frame flag, tagReg[SLOT_COUNT-k] the tag of slot k
  logic [SLOT_COUNT:0]   tagReg;
  logic [SLOT_WIDTH-2:0] shiftReg;
  logic                  tagHit;

  always_comb begin
    tagHit = 1'b0;
    for (int k = 1; k <= SLOT_COUNT; k++) begin
      if (slotIdx == NUM_W'(k)) tagHit = tagReg[SLOT_COUNT-k];
    end
  end

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      tagReg    <= '0;
      shiftReg  <= '0;
      slotData  <= '0;
      slotNum   <= '0;
      slotValid <= 1'b0;
    end else begin
      if (strobes.tagShift)  tagReg   <= {tagReg[SLOT_COUNT-1:0], serData};
      if (strobes.slotShift) shiftReg <= {shiftReg[SLOT_WIDTH-3:0], serData};
      slotValid <= strobes.slotLast && tagReg[SLOT_COUNT] && tagHit;
      if (strobes.slotLast) begin
        slotData <= {shiftReg, serData};
        slotNum  <= slotIdx;
      end
    end
  end

  // R4
  strobe_single_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    slotValid |=> !slotValid);

  // R4
  slot_num_range_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    slotValid |-> (slotNum != '0 && int'(slotNum) <= SLOT_COUNT));

  // R6
  frame_flag_gate_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    slotValid |-> tagReg[SLOT_COUNT]);

endmodule

// File: rtl/audio_link_rx.sv
`timescale 1ns/1ps
module audio_link_rx
  import audio_link_rx_pkg::*;
#(
  parameter int TAG_WIDTH  = 16,
  parameter int SLOT_WIDTH = 20,
  parameter int SLOT_COUNT = 12,
  localparam int NUM_W = $clog2(SLOT_COUNT + 1)
) (
  input  logic                  bitClk,
  input  logic                  rstN,
  input  logic                  syncIn,
  input  logic                  serData,
  output logic [SLOT_WIDTH-1:0] slotData,
  output logic [NUM_W-1:0]      slotNum,
  output logic                  slotValid,
  output logic                  frameErr
);

  rxStrobes_t       strobes;
  logic [NUM_W-1:0] slotIdx;

  rx_frame_ctrl #(
    .TAG_WIDTH (TAG_WIDTH),
    .SLOT_WIDTH(SLOT_WIDTH),
    .SLOT_COUNT(SLOT_COUNT)
  ) ctrl (
    .bitClk  (bitClk),
    .rstN    (rstN),
    .syncIn  (syncIn),
    .strobes (strobes),
    .slotIdx (slotIdx),
    .frameErr(frameErr)
  );

  rx_slot_datapath #(
    .SLOT_WIDTH(SLOT_WIDTH),
    .SLOT_COUNT(SLOT_COUNT)
  ) datapath (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .serData  (serData),
    .strobes  (strobes),
    .slotIdx  (slotIdx),
    .slotData (slotData),
    .slotNum  (slotNum),
    .slotValid(slotValid)
  );

  // R10
  reset_quiet_chk: assert property (@(negedge bitClk)
    !rstN |-> (!slotValid && !frameErr));

endmodule

// File: tb/audio_link_rx_test.sv
`timescale 1ns/1ps
module audio_link_rx_test;

  localparam int SC    = 4;
  localparam int SW    = 8;
  localparam int TW    = 16;
  localparam int NW    = $clog2(SC + 1);
  localparam int FRAME = TW + SC * SW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          syncIn = 1'b0;
  logic          serData = 1'b0;
  logic [SW-1:0] slotData;
  logic [NW-1:0] slotNum;
  logic          slotValid;
  logic          frameErr;

  always #2.5 clk = ~clk;

  audio_link_rx #(.TAG_WIDTH(TW), .SLOT_WIDTH(SW), .SLOT_COUNT(SC)) uut (
    .bitClk(clk), .rstN(rstN), .syncIn(syncIn), .serData(serData),
    .slotData(slotData), .slotNum(slotNum), .slotValid(slotValid), .frameErr(frameErr)
  );

  // {tag slot, data seed}; frame flag is tag bit 15, slot k tag is bit 15-k
  localparam logic [23:0] VECS [6] = '{
    {16'hF800, 8'hA5},  // every slot tagged
    {16'hA800, 8'h3C},  // slots 2 and 4
    {16'h7800, 8'h96},  // frame flag clear
    {16'h8000, 8'h0F},  // flag only, no slot tagged
    {16'hC000, 8'hE1},  // slot 1 only
    {16'h98FF, 8'h5B}   // slots 3 and 4, unused tag bits set
  };

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  logic          pendV = 1'b0;
  logic [SW-1:0] pendD = '0;
  logic [NW-1:0] pendN = '0;
  logic          pendE = 1'b0;
  string         pendR = "R10";

  function automatic logic [SW-1:0] slotWord(input logic [7:0] seed, input int k);
    return SW'(seed * (k + 1)) ^ SW'(8'h5A);
  endfunction

  // One bit clock: check what the last falling edge produced, then launch the next bit
  task automatic step(input logic s, input logic d, input logic v, input logic [SW-1:0] ed,
                      input logic [NW-1:0] en, input logic e, input string r);
    @(posedge clk);
    checks++;
    if (slotValid !== pendV || frameErr !== pendE ||
        (pendV && (slotData !== pendD || slotNum !== pendN))) begin
      fails++;
      $display("FAIL %s: valid=%0b num=%0d data=%h err=%0b, expected valid=%0b num=%0d data=%h err=%0b",
               pendR, slotValid, slotNum, slotData, frameErr, pendV, pendN, pendD, pendE);
    end
    pendV = v; pendD = ed; pendN = en; pendE = e; pendR = r;
    syncIn = s; serData = d;
  endtask

  task automatic leadIn(input logic errExp, input string r);
    step(1'b1, 1'b0, 1'b0, '0, '0, errExp, r);
  endtask

  task automatic idle(input int n, input string r);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, r);
  endtask

  // Sync is high for the 15 tag bits after the lead-in bit, and again on the last bit if chained
  task automatic sendFrame(input logic [15:0] tag, input logic [7:0] seed, input bit nextSync,
                           input int cutAt, input string r);
    for (int i = 0; i < cutAt; i++) begin
      logic          b;
      logic          v;
      logic [SW-1:0] w;
      logic [NW-1:0] k;
      logic          s;
      string         lbl;
      v = 1'b0; w = '0; k = '0; lbl = r;
      if (i < TW) begin
        b = tag[TW-1-i];                         // R2: tag bits in arrival order
      end else begin
        k = NW'((i - TW) / SW + 1);
        w = slotWord(seed, int'(k));
        b = w[SW-1-((i - TW) % SW)];             // R3: MSB first
        if ((i - TW) % SW == SW - 1 && tag[15] && tag[15-int'(k)]) v = 1'b1;
      end
      s = (i < TW - 1) || (i == FRAME - 1 && nextSync);
      if (i == FRAME - 1 && nextSync) lbl = "R7";
      step(s, b, v, w, k, 1'b0, lbl);
    end
  endtask

  function automatic string reqFor(input logic [15:0] tag);
    if (!tag[15]) return "R6";
    if (tag[14:11] != 4'hF) return "R5";
    return "R4";
  endfunction

  initial begin
    // R10: outputs quiet in reset, even with sync toggling
    step(1'b1, 1'b1, 1'b0, '0, '0, 1'b0, "R10");
    step(1'b0, 1'b1, 1'b0, '0, '0, 1'b0, "R10");
    step(1'b0, 1'b0, 1'b0, '0, '0, 1'b0, "R10");
    rstN = 1'b1;
    idle(2, "R1");
    leadIn(1'b0, "R9");                          // R9: first start after reset raises no error

    // Table walk: back-to-back aligned frames (R1, R4, R5, R6, R7)
    for (int n = 0; n < 6; n++) begin
      sendFrame(VECS[n][23:8], VECS[n][7:0], 1'b1, FRAME, reqFor(VECS[n][23:8]));
    end
    sendFrame(16'hF800, 8'h21, 1'b0, FRAME, "R4");

    // R8: early restart inside slot 2; slot 1 presented, slot 2 discarded
    idle(3, "R9");
    leadIn(1'b1, "R9");                          // late start after idle gap
    sendFrame(16'hF800, 8'h33, 1'b0, TW + SW + 6, "R8");
    leadIn(1'b1, "R8");
    sendFrame(16'hF800, 8'h44, 1'b0, FRAME, "R8");

    // R9: no sync after the final slot -> silence, then an error on the late start
    idle(6, "R9");
    leadIn(1'b1, "R9");
    sendFrame(16'hC800, 8'h77, 1'b1, FRAME, "R5");
    sendFrame(16'h8800, 8'h19, 1'b0, FRAME, "R5");
    idle(3, "R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule